// File: doc/BRIEF.md
# Sprite Texel Fetch and Sub-Palette Colour Resolve

This block sits at the end of a sprite pixel pipeline. For each pixel it receives a match flag, the matched sprite's 16-bit texture reference and width, and the pixel's row and column inside the sprite. It forms a byte address into a 16 KB texture store, reads the byte there, and uses that byte's low nibble together with a sub-palette selector to read a 16-bit colour from a 64-entry colour table. Texture references point at 4-byte aligned data, so their two lowest bits are free; they carry the selector for one of four 16-entry sub-palettes. When the pixel has no match, a background colour given at a port is produced instead.

A host write port loads the colour table, the texture store and a 2 KB sprite descriptor store. The colour table may be written at any time. The texture and descriptor stores accept writes only while an upload-mode input is high, which software is expected to raise during vertical blanking. A write to either of them outside upload mode is dropped and sets a sticky error flag. The descriptor store has a read port for the sprite matching logic.

Top module: `tex_palette_fetch`

## Requirements
- R1: After reset, `out_valid` is 0 and `wr_err` is 0.
- R2: A pixel presented with `px_valid` high at clock edge k appears with `out_valid` high after edge k+1; `out_valid` is low in every cycle that has no such pixel.
- R3: The texel byte address is ({ref[15:2], 2'b00} + row × width + column) modulo 16384; the texture store holds 32-bit words at word address = byte address[13:2], and byte lane n (byte address[1:0] = n) is word bits [8n+7:8n].
- R4: The colour table index is {ref[1:0], texel[3:0]}; texel bits [7:4] have no effect on the colour.
- R5: A pixel with `px_hit` low produces `bg_color` as it stood at edge k+1.
- R6: A host write with target code 2 writes `host_wr_data[15:0]` into colour entry `host_wr_addr[5:0]` whether or not upload mode is on, and never sets `wr_err`.
- R7: A host write with target code 0 writes the 32-bit word at word address `host_wr_addr[11:0]` of the texture store only while `upload_en` is high; otherwise the store is unchanged.
- R8: A host write with target code 1 writes descriptor word `host_wr_addr[8:0]` only while `upload_en` is high; `spr_rd_data` shows the word at `spr_rd_addr` one edge after the address is applied.
- R9: A target-0 or target-1 write made while `upload_en` is low sets `wr_err`, which then stays 1 until reset.
- R10: A host write with target code 3 changes no store and does not set `wr_err`.
- R11: When a colour-table write and a colour read of the same entry happen at the same edge, or a texture write and a texel read of the same word, the pixel receives the old value; later pixels receive the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upload_en | input | 1 | Upload mode: enables texture and descriptor writes |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_tgt | input | 2 | Write target: 0 texture, 1 descriptor, 2 colour table, 3 none |
| host_wr_addr | input | 12 | Word address within the target |
| host_wr_data | input | 32 | Write data (colour table uses bits 15:0) |
| bg_color | input | 16 | Colour for pixels without a sprite match |
| px_valid | input | 1 | Pixel request valid |
| px_hit | input | 1 | Pixel is covered by a matched sprite |
| px_tex_ref | input | 16 | Sprite texture reference with sub-palette in bits 1:0 |
| px_width | input | 8 | Sprite width in texels |
| px_row | input | 8 | Row inside the sprite |
| px_col | input | 8 | Column inside the sprite |
| spr_rd_addr | input | 9 | Descriptor store read address |
| spr_rd_data | output | 32 | Descriptor store read data |
| out_valid | output | 1 | Output colour valid |
| out_color | output | 16 | Resolved pixel colour |
| wr_err | output | 1 | Sticky flag for a gated write refused |

## Verification
A host write and a pixel lookup can land on the same storage in the same cycle: a colour-table write can hit the entry that an in-flight pixel reads at its second edge, and an upload-mode texture write can hit the word that a new pixel reads at its first edge. The bench provokes both by timing the write strobe against the pixel strobe to the exact edge, then judges that the colliding pixel carries the old colour and that the next pixel to the same location carries the new one.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
   typedef enum logic [1:0] {
      TGT_TEX  = 2'd0,
      TGT_SPR  = 2'd1,
      TGT_PAL  = 2'd2,
      TGT_NONE = 2'd3
   } tfp_tgt_e;
endpackage

// File: rtl/tfp_ram.sv
module tfp_ram #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tfp_ram: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   // read returns the stored word as it was before a same-edge write
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/tfp_addr_gen.sv
module tfp_addr_gen #(
   parameter int REF_W   = 16,
   parameter int COORD_W = 8,
   parameter int TEX_AW  = 14,
   parameter int SEL_W   = 2
) (
   input  logic [REF_W-1:0]   tex_ref,
   input  logic [COORD_W-1:0] width,
   input  logic [COORD_W-1:0] row,
   input  logic [COORD_W-1:0] col,
   output logic [TEX_AW-1:0]  byte_addr,
   output logic [SEL_W-1:0]   sub_sel
);
   localparam int PROD_W = 2 * COORD_W;
   localparam int SUM_W  = (PROD_W > REF_W ? PROD_W : REF_W) + 1;

   if (REF_W <= SEL_W) begin : g_bad_ref
      $error("tfp_addr_gen: reference too narrow for selector");
   end

   logic [PROD_W-1:0] line_off;
   logic [SUM_W-1:0]  full_sum;

   always_comb begin
      line_off  = PROD_W'(row) * PROD_W'(width);
      full_sum  = SUM_W'({tex_ref[REF_W-1:SEL_W], {SEL_W{1'b0}}})
                + SUM_W'(line_off) + SUM_W'(col);
      byte_addr = full_sum[TEX_AW-1:0];
      sub_sel   = tex_ref[SEL_W-1:0];
   end
endmodule

// File: rtl/tfp_lane_pick.sv
module tfp_lane_pick #(
   parameter int WORD_W = 32,
   parameter int NIB_W  = 4,
   localparam int LANES  = WORD_W / 8,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [LANE_W-1:0] lane,
   output logic [NIB_W-1:0]  index
);
   if (NIB_W > 8 || NIB_W < 1) begin : g_bad_nib
      $error("tfp_lane_pick: index must fit in one byte");
   end

   logic [7:0] texel;

   if (LANES == 1) begin : g_single
      assign texel = word[7:0];
   end else begin : g_multi
      always_comb begin
         texel = '0;
         for (int i = 0; i < LANES; i++)
            if (lane == LANE_W'(i)) texel = word[8*i +: 8];
      end
   end

   assign index = texel[NIB_W-1:0];
endmodule

// File: rtl/tex_palette_fetch.sv
module tex_palette_fetch
   import tfp_pkg::*;
#(
   parameter int REF_W       = 16,
   parameter int COORD_W     = 8,
   parameter int TEX_BYTES   = 16384,
   parameter int TEX_WORD_W  = 32,
   parameter int SPR_BYTES   = 2048,
   parameter int COLOR_W     = 16,
   parameter int SUBPALS     = 4,
   parameter int SUB_ENTRIES = 16,
   parameter int HOST_AW     = 12,
   localparam int SPR_AW     = $clog2(SPR_BYTES / 4)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  upload_en,
   input  logic                  host_wr_en,
   input  logic [1:0]            host_wr_tgt,
   input  logic [HOST_AW-1:0]    host_wr_addr,
   input  logic [31:0]           host_wr_data,
   input  logic [COLOR_W-1:0]    bg_color,
   input  logic                  px_valid,
   input  logic                  px_hit,
   input  logic [REF_W-1:0]      px_tex_ref,
   input  logic [COORD_W-1:0]    px_width,
   input  logic [COORD_W-1:0]    px_row,
   input  logic [COORD_W-1:0]    px_col,
   input  logic [SPR_AW-1:0]     spr_rd_addr,
   output logic [31:0]           spr_rd_data,
   output logic                  out_valid,
   output logic [COLOR_W-1:0]    out_color,
   output logic                  wr_err
);
   localparam int TEX_AW    = $clog2(TEX_BYTES);
   localparam int LANES     = TEX_WORD_W / 8;
   localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int TEX_DEPTH = TEX_BYTES / LANES;
   localparam int TEX_WA    = $clog2(TEX_DEPTH);
   localparam int SPR_DEPTH = SPR_BYTES / 4;
   localparam int SEL_W     = $clog2(SUBPALS);
   localparam int NIB_W     = $clog2(SUB_ENTRIES);
   localparam int PAL_DEPTH = SUBPALS * SUB_ENTRIES;
   localparam int PAL_AW    = SEL_W + NIB_W;

   // elaboration checks
   if (SEL_W != 2 || LANES != 4) begin : g_bad_align
      $error("tex_palette_fetch: selector must fill the 4-byte alignment bits");
   end
   if (HOST_AW < TEX_WA || HOST_AW < SPR_AW || HOST_AW < PAL_AW) begin : g_bad_host
      $error("tex_palette_fetch: host address too narrow");
   end
   if (COLOR_W > 32 || TEX_WORD_W > 32) begin : g_bad_data
      $error("tex_palette_fetch: host data too narrow");
   end

   tfp_tgt_e tgt;
   logic     tex_we, spr_we, pal_we, gated_try;

   always_comb begin
      tgt       = tfp_tgt_e'(host_wr_tgt);
      tex_we    = host_wr_en && upload_en && (tgt == TGT_TEX);
      spr_we    = host_wr_en && upload_en && (tgt == TGT_SPR);
      pal_we    = host_wr_en && (tgt == TGT_PAL);
      gated_try = host_wr_en && !upload_en && (tgt == TGT_TEX || tgt == TGT_SPR);
   end

   always_ff @(posedge clk) begin
      if (rst)            wr_err <= 1'b0;
      else if (gated_try) wr_err <= 1'b1;
   end

   // stage 0: address
   logic [TEX_AW-1:0] byte_addr;
   logic [SEL_W-1:0]  sub_sel;

   tfp_addr_gen #(.REF_W(REF_W), .COORD_W(COORD_W), .TEX_AW(TEX_AW), .SEL_W(SEL_W)) u_addr (
      .tex_ref(px_tex_ref), .width(px_width), .row(px_row), .col(px_col),
      .byte_addr(byte_addr), .sub_sel(sub_sel)
   );

   // stage 1: texture read
   logic [TEX_WORD_W-1:0] tex_word;
   logic                  v1, hit1;
   logic [SEL_W-1:0]      sel1;
   logic [LANE_W-1:0]     lane1;

   tfp_ram #(.DEPTH(TEX_DEPTH), .WIDTH(TEX_WORD_W)) u_tex (
      .clk(clk), .we(tex_we), .waddr(host_wr_addr[TEX_WA-1:0]),
      .wdata(host_wr_data[TEX_WORD_W-1:0]),
      .raddr(byte_addr[TEX_AW-1:LANE_W]), .rdata(tex_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v1 <= 1'b0;
         hit1 <= 1'b0;
      end else begin
         v1 <= px_valid;
         hit1 <= px_hit;
      end
      sel1  <= sub_sel;
      lane1 <= byte_addr[LANE_W-1:0];
   end

   // stage 2: palette read
   logic [NIB_W-1:0]   nib;
   logic [COLOR_W-1:0] pal_color, bg2;
   logic               hit2;

   tfp_lane_pick #(.WORD_W(TEX_WORD_W), .NIB_W(NIB_W)) u_pick (
      .word(tex_word), .lane(lane1), .index(nib)
   );

   tfp_ram #(.DEPTH(PAL_DEPTH), .WIDTH(COLOR_W)) u_pal (
      .clk(clk), .we(pal_we), .waddr(host_wr_addr[PAL_AW-1:0]),
      .wdata(host_wr_data[COLOR_W-1:0]),
      .raddr({sel1, nib}), .rdata(pal_color)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         hit2 <= 1'b0;
      end else begin
         out_valid <= v1;
         hit2 <= hit1;
      end
      bg2 <= bg_color;
   end

   assign out_color = hit2 ? pal_color : bg2;

   // descriptor store
   tfp_ram #(.DEPTH(SPR_DEPTH), .WIDTH(32)) u_spr (
      .clk(clk), .we(spr_we), .waddr(host_wr_addr[SPR_AW-1:0]),
      .wdata(host_wr_data), .raddr(spr_rd_addr), .rdata(spr_rd_data)
   );

   // assertions
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
      v1 |=> out_valid);
   p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !v1 |=> !out_valid);
   p_bg_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
      (v1 && !hit1) |=> (out_color == $past(bg_color)));
   p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
      (host_wr_en && !upload_en && host_wr_tgt inside {2'd0, 2'd1}) |=> wr_err);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      wr_err |=> wr_err);
   p_no_err_pal_r6: assert property (@(posedge clk) disable iff (rst)
      (!wr_err && host_wr_en && host_wr_tgt == 2'd2) |=> !wr_err);
   p_no_err_none_r10: assert property (@(posedge clk) disable iff (rst)
      (!wr_err && host_wr_en && host_wr_tgt == 2'd3) |=> !wr_err);
endmodule

// File: tb/tb_tex_palette_fetch.sv
module tb_tex_palette_fetch;
   logic        clk = 1'b0;
   logic        rst, upload_en, host_wr_en;
   logic [1:0]  host_wr_tgt;
   logic [11:0] host_wr_addr;
   logic [31:0] host_wr_data;
   logic [15:0] bg_color;
   logic        px_valid, px_hit;
   logic [15:0] px_tex_ref;
   logic [7:0]  px_width, px_row, px_col;
   logic [8:0]  spr_rd_addr;
   logic [31:0] spr_rd_data;
   logic        out_valid, wr_err;
   logic [15:0] out_color;

   always #5 clk = ~clk;

   tex_palette_fetch dut (
      .clk(clk), .rst(rst), .upload_en(upload_en), .host_wr_en(host_wr_en),
      .host_wr_tgt(host_wr_tgt), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .bg_color(bg_color), .px_valid(px_valid), .px_hit(px_hit), .px_tex_ref(px_tex_ref),
      .px_width(px_width), .px_row(px_row), .px_col(px_col), .spr_rd_addr(spr_rd_addr),
      .spr_rd_data(spr_rd_data), .out_valid(out_valid), .out_color(out_color), .wr_err(wr_err)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [31:0] tm [0:4095];
   logic [15:0] pm [0:63];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   function automatic logic [15:0] expc(input logic [15:0] r, input logic [7:0] w,
                                        input logic [7:0] row, input logic [7:0] col);
      int a;
      logic [31:0] wd;
      logic [7:0] b;
      a = ((int'(r) & 32'hFFFC) + int'(row) * int'(w) + int'(col)) & 16383;
      wd = tm[a >> 2];
      b = wd[8*(a & 3) +: 8];
      return pm[{r[1:0], b[3:0]}];
   endfunction

   task automatic hw(input logic [1:0] t, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr_en = 1; host_wr_tgt = t; host_wr_addr = a; host_wr_data = d;
      @(negedge clk);
      host_wr_en = 0;
   endtask

   task automatic drive_px(input logic h, input logic [15:0] r, input logic [7:0] w,
                           input logic [7:0] row, input logic [7:0] col);
      px_valid = 1; px_hit = h; px_tex_ref = r; px_width = w; px_row = row; px_col = col;
   endtask

   task automatic lookup(input string req, input logic h, input logic [15:0] r,
                         input logic [7:0] w, input logic [7:0] row, input logic [7:0] col);
      logic [15:0] e;
      e = h ? expc(r, w, row, col) : bg_color;
      @(negedge clk);
      drive_px(h, r, w, row, col);
      @(negedge clk);
      px_valid = 0;
      chk({req, " R2 no early valid"}, 32'(out_valid), 32'd0);
      @(negedge clk);
      chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
      chk({req, " colour"}, 32'(out_color), 32'(e));
      @(negedge clk);
      chk({req, " R2 valid drops"}, 32'(out_valid), 32'd0);
   endtask

   task automatic t_reset();
      rst = 1; upload_en = 0; host_wr_en = 0; host_wr_tgt = 0; host_wr_addr = 0;
      host_wr_data = 0; bg_color = 16'h0BAD; px_valid = 0; px_hit = 0; px_tex_ref = 0;
      px_width = 0; px_row = 0; px_col = 0; spr_rd_addr = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      chk("R1 out_valid", 32'(out_valid), 32'd0);
      chk("R1 wr_err", 32'(wr_err), 32'd0);
   endtask

   task automatic t_load();
      upload_en = 1;
      for (int i = 0; i < 64; i++) begin
         pm[i] = 16'hA000 + 16'(i * 16'h0105);
         hw(2'd2, 12'(i), 32'(pm[i]));
      end
      tm[12'h049] = 32'hF73C1902; hw(2'd0, 12'h049, tm[12'h049]);
      tm[12'h000] = 32'h5BE4A681; hw(2'd0, 12'h000, tm[12'h000]);
      tm[12'h010] = 32'h3A2B1C0D; hw(2'd0, 12'h010, tm[12'h010]);
   endtask

   task automatic t_none_target();
      hw(2'd3, 12'h049, 32'h0);
      hw(2'd3, 12'h000, 32'hFFFF_FFFF);
      chk("R10 no error", 32'(wr_err), 32'd0);
      lookup("R10 texture kept", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
   endtask

   task automatic t_address();
      lookup("R3 row*width+col sub2", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
      chk("R3 R4 known colour", 32'(expc(16'h0106, 8'd10, 8'd3, 8'd5)), 32'(pm[39]));
      lookup("R4 sub3 same texel", 1, 16'h0107, 8'd10, 8'd3, 8'd5);
      lookup("R3 wrap at 16K", 1, 16'hFFFC, 8'd0, 8'd0, 8'd6);
      lookup("R3 lane0 sub1", 1, 16'h0041, 8'd4, 8'd0, 8'd0);
      lookup("R4 high nibble ignored", 1, 16'h0040, 8'd2, 8'd1, 8'd1);
   endtask

   task automatic t_miss();
      bg_color = 16'h7E57;
      lookup("R5 background", 0, 16'h0106, 8'd10, 8'd3, 8'd5);
   endtask

   task automatic t_pal_anytime();
      upload_en = 0;
      pm[39] = 16'h1234;
      hw(2'd2, 12'd39, 32'h0000_1234);
      chk("R6 no error", 32'(wr_err), 32'd0);
      lookup("R6 palette updated", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
   endtask

   task automatic t_sprite();
      upload_en = 1;
      hw(2'd1, 12'd5, 32'hCAFEF00D);
      spr_rd_addr = 9'd5;
      @(negedge clk);
      chk("R8 descriptor written", spr_rd_data, 32'hCAFEF00D);
      chk("R8 no error", 32'(wr_err), 32'd0);
      upload_en = 0;
      hw(2'd1, 12'd5, 32'h1111_1111);
      @(negedge clk);
      chk("R8 descriptor kept", spr_rd_data, 32'hCAFEF00D);
      chk("R9 error set", 32'(wr_err), 32'd1);
   endtask

   task automatic t_tex_gated();
      upload_en = 0;
      hw(2'd0, 12'h049, 32'h0000_0000);
      lookup("R7 texture kept", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
      chk("R9 error sticky", 32'(wr_err), 32'd1);
      upload_en = 1;
      hw(2'd2, 12'd0, 32'h0);
      pm[0] = 16'h0;
      chk("R9 still set", 32'(wr_err), 32'd1);
   endtask

   task automatic t_collide_pal();
      logic [15:0] old_c;
      old_c = expc(16'h0106, 8'd10, 8'd3, 8'd5);
      @(negedge clk);
      drive_px(1, 16'h0106, 8'd10, 8'd3, 8'd5);
      @(negedge clk);
      px_valid = 0;
      host_wr_en = 1; host_wr_tgt = 2'd2; host_wr_addr = 12'd39; host_wr_data = 32'h0000_5A5A;
      @(negedge clk);
      host_wr_en = 0;
      chk("R11 palette collision old", 32'(out_color), 32'(old_c));
      pm[39] = 16'h5A5A;
      lookup("R11 palette new after", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
   endtask

   task automatic t_collide_tex();
      logic [15:0] old_c;
      upload_en = 1;
      old_c = expc(16'h0106, 8'd10, 8'd3, 8'd5);
      @(negedge clk);
      drive_px(1, 16'h0106, 8'd10, 8'd3, 8'd5);
      host_wr_en = 1; host_wr_tgt = 2'd0; host_wr_addr = 12'h049; host_wr_data = 32'h0C000000;
      @(negedge clk);
      px_valid = 0; host_wr_en = 0;
      @(negedge clk);
      chk("R11 texture collision old", 32'(out_color), 32'(old_c));
      tm[12'h049] = 32'h0C000000;
      lookup("R7 R11 texture new after", 1, 16'h0106, 8'd10, 8'd3, 8'd5);
      chk("R7 new colour index", 32'(expc(16'h0106, 8'd10, 8'd3, 8'd5)), 32'(pm[44]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset();
      t_load();
      t_none_target();
      t_address();
      t_miss();
      t_pal_anytime();
      t_collide_pal();
      t_collide_tex();
      t_sprite();
      t_tex_gated();
      done = 1;
      summary();
      $finish;
   end
endmodule